// File: doc/BRIEF.md
# Variable-Resolution SAR Conversion Sequencer

This block is the digital sequencer for a charge-redistribution successive-approximation converter. The resolution of that converter can be set anywhere from 3 to 8 bits. The sequencer runs conversions back to back with no gap between them. Each conversion is a frame of ten slots, and each slot lasts two clock cycles. The first cycle of a slot resets the comparator. The second cycle lets the comparator evaluate.

The frame runs in a fixed order:
- one sample slot, in which the reference switch is closed and the bottom plates are held at the reference;
- one hold slot, in which the reference switch opens first and the plates are grounded one cycle later;
- N decision slots, most significant bit first;
- idle slots for whatever remains of the frame.

When the chosen resolution is N, the capacitors and register stages above bit N-1 stay off, held at zero. The first bit trial starts at bit N-1.

The requested width is clamped to the supported range and taken only at a frame boundary. The result is right-aligned in an 8-bit word and comes with a one-cycle done strobe.

Top module: `sar_seq_ctrl`

## Requirements
- R1: `width_i` below 3 gives N = 3, and `width_i` above 8 gives N = 8. Values 3 to 8 give N = `width_i`.
- R2: `width_i` is taken only at the clock edge that ends cycle 19 of a frame. A change at any other time has no effect on the conversion in progress. After reset, N = 8.
- R3: A frame is 20 cycles, numbered 0 to 19, and slot s covers cycles 2s and 2s+1. Slot 0 samples, slot 1 holds, slots 2 to N+1 decide, and the remaining slots are idle. `done_o` is high for exactly the one cycle after the last decision edge.
- R4: `ref_sw_o` is 1 in both cycles of slot 0 and 0 in every other cycle.
- R5: A 1 in bit b of `cap_drv_o` ties capacitor b's bottom plate to the reference, and a 0 grounds it. Every enabled bit is 1 in slot 0 and in cycle 2. All bits are 0 in cycle 3 and in idle slots.
- R6: Bit b of `cap_en_o` is 1 exactly when b < N. A disabled bit of `cap_drv_o` is always 0.
- R7: Bit k of `stage_en_o` (k = 0..4) is 1 exactly when N > 3+k. This gives a thermometer code.
- R8: `comp_rst_o` is 0 only in the second cycle of a decision slot.
- R9: In decision slot 2+d, the bit under trial is b = N-1-d. In that slot, `cap_drv_o` shows b set, the bits above b as already decided, and the bits below b as 0. `comp_i` is sampled at the end of the slot, and `comp_i` = 1 keeps bit b.
- R10: `result_o` carries the N decided bits in `[N-1:0]`, with the upper bits 0. It updates only in the cycle where `done_o` is 1 and holds otherwise.
- R11: During reset and in the first cycle after it, the outputs show cycle 0 at N = 8: `result_o` = 0 and `done_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is half a slot |
| rst | input | 1 | Synchronous active-high reset |
| width_i | input | 4 | Requested resolution in bits |
| comp_i | input | 1 | Comparator decision, 1 = input at or above the DAC level |
| ref_sw_o | output | 1 | Closes the reference switch (sample phase) |
| cap_en_o | output | 8 | Per-capacitor enable for both plate switches |
| stage_en_o | output | 5 | Enables for the five removable high-order stages |
| cap_drv_o | output | 8 | Bottom-plate select, 1 = reference, 0 = ground |
| comp_rst_o | output | 1 | Comparator reset |
| result_o | output | 8 | Right-aligned conversion result |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The main function is checked with inputs at both rails, at both sides of mid-scale, and at patterns of alternating bits.
- The rail inputs show whether every trial is kept or every trial is dropped.
- The inputs either side of mid-scale separate a wrong decision on the most significant bit from a wrong decision on a lower bit.
- The alternating-bit patterns expose a stage that is shifted or swapped.

Each of the six widths is also run, and so are out-of-range requests at both ends. This shows whether truncation starts at the right stage and whether the clamp picks the nearest legal width.

Width changes in the middle of a frame are also driven, including back-to-back frames at very different widths. These separate a width that is taken at the frame boundary from one that leaks into a conversion already in progress.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned SEQ_MAX_W        = 8;
    localparam int unsigned SEQ_MIN_W        = 3;
    localparam int unsigned SEQ_SLOTS        = 10;
    localparam int unsigned SEQ_CYC_PER_SLOT = 2;
    localparam int unsigned SEQ_WREQ_W       = 4;

    typedef enum logic [1:0] {
        SLOT_SAMPLE = 2'd0,
        SLOT_HOLD   = 2'd1,
        SLOT_DECIDE = 2'd2,
        SLOT_IDLE   = 2'd3
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic       first;
        logic       last;
        logic       frame_end;
    } slot_pos_t;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/sar_slot_timer.sv
module sar_slot_timer
    import sar_seq_pkg::*;
#(
    parameter int unsigned SLOTS  = SEQ_SLOTS,
    parameter int unsigned CPS    = SEQ_CYC_PER_SLOT,
    parameter int unsigned WREQ_W = SEQ_WREQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WREQ_W-1:0] width_i,
    output slot_pos_t         pos_o
);
    localparam int unsigned PH_W = (CPS > 1) ? $clog2(CPS) : 1;
    localparam int unsigned SL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [PH_W-1:0] PH_LAST   = PH_W'(CPS - 1);
    localparam logic [SL_W-1:0] SLOT_LAST = SL_W'(SLOTS - 1);

    logic [PH_W-1:0] ph_q;
    logic [SL_W-1:0] slot_q;
    logic            ph_last;
    logic            at_end;

    assign ph_last = (ph_q == PH_LAST);
    assign at_end  = ph_last && (slot_q == SLOT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            slot_q <= '0;
        end else if (ph_last) begin
            ph_q   <= '0;
            slot_q <= at_end ? '0 : slot_q + 1'b1;
        end else begin
            ph_q   <= ph_q + 1'b1;
        end
    end

    always_comb begin
        pos_o.first     = (ph_q == '0);
        pos_o.last      = ph_last;
        pos_o.frame_end = at_end;
        if (slot_q == '0)
            pos_o.kind = SLOT_SAMPLE;
        else if (slot_q == SL_W'(1))
            pos_o.kind = SLOT_HOLD;
        else if (int'(slot_q) < 2 + int'(width_i))
            pos_o.kind = SLOT_DECIDE;
        else
            pos_o.kind = SLOT_IDLE;
    end

endmodule

// File: rtl/sar_width_cfg.sv
module sar_width_cfg
    import sar_seq_pkg::*;
#(
    parameter int unsigned MAX_W  = SEQ_MAX_W,
    parameter int unsigned MIN_W  = SEQ_MIN_W,
    parameter int unsigned WREQ_W = SEQ_WREQ_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_i,
    input  logic [WREQ_W-1:0]      req_i,
    output logic [WREQ_W-1:0]      width_o,
    output logic [MAX_W-1:0]       cap_en_o,
    output logic [MAX_W-MIN_W-1:0] stage_en_o
);
    localparam int unsigned SPARE = MAX_W - MIN_W;

    logic [WREQ_W-1:0] width_q;
    logic [WREQ_W-1:0] width_d;

    assign width_d = WREQ_W'(clamp_int(int'(req_i), int'(MIN_W), int'(MAX_W)));

    always_ff @(posedge clk) begin
        if (rst)
            width_q <= WREQ_W'(MAX_W);
        else if (load_i)
            width_q <= width_d;
    end

    assign width_o = width_q;

    for (genvar g = 0; g < MAX_W; g++) begin : g_cap
        assign cap_en_o[g] = (int'(width_q) > g);
    end

    for (genvar k = 0; k < SPARE; k++) begin : g_stage
        assign stage_en_o[k] = cap_en_o[MIN_W + k];
    end

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
    import sar_seq_pkg::*;
#(
    parameter int unsigned MAX_W = SEQ_MAX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             seed_i,
    input  logic             step_i,
    input  logic             comp_i,
    input  logic [MAX_W-1:0] cap_en_i,
    output logic [MAX_W-1:0] bits_o,
    output logic [MAX_W-1:0] bits_next_o,
    output logic             finish_o
);
    logic [MAX_W-1:0] bits_q, trial_q;
    logic [MAX_W-1:0] nb, nt;
    logic [MAX_W-1:0] en_up, trial_up;

    assign en_up    = {1'b0, cap_en_i[MAX_W-1:1]};
    assign trial_up = {1'b0, trial_q[MAX_W-1:1]};

    for (genvar g = 0; g < MAX_W; g++) begin : g_stage
        logic top_bit;
        assign top_bit = cap_en_i[g] & ~en_up[g];
        assign nt[g] = seed_i ? top_bit :
                       step_i ? trial_up[g] : trial_q[g];
        assign nb[g] = cap_en_i[g] & (
                       seed_i ? top_bit :
                       step_i ? (trial_q[g] ? comp_i : (trial_up[g] | bits_q[g])) :
                       bits_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            bits_q  <= '0;
            trial_q <= '0;
        end else begin
            bits_q  <= nb;
            trial_q <= nt;
        end
    end

    assign bits_o      = bits_q;
    assign bits_next_o = nb;
    assign finish_o    = step_i & trial_q[0];

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned MAX_W  = SEQ_MAX_W,
    parameter int unsigned MIN_W  = SEQ_MIN_W,
    parameter int unsigned SLOTS  = SEQ_SLOTS,
    parameter int unsigned CPS    = SEQ_CYC_PER_SLOT,
    parameter int unsigned WREQ_W = SEQ_WREQ_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WREQ_W-1:0]      width_i,
    input  logic                   comp_i,
    output logic                   ref_sw_o,
    output logic [MAX_W-1:0]       cap_en_o,
    output logic [MAX_W-MIN_W-1:0] stage_en_o,
    output logic [MAX_W-1:0]       cap_drv_o,
    output logic                   comp_rst_o,
    output logic [MAX_W-1:0]       result_o,
    output logic                   done_o
);
    slot_pos_t         pos;
    logic [WREQ_W-1:0] width_q;
    logic [MAX_W-1:0]  cap_en;
    logic [MAX_W-1:0]  bits, bits_next;
    logic              finish;
    logic              seed, step;
    logic [MAX_W-1:0]  result_q;
    logic              done_q;

    sar_slot_timer #(.SLOTS(SLOTS), .CPS(CPS), .WREQ_W(WREQ_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .width_i (width_q),
        .pos_o   (pos)
    );

    sar_width_cfg #(.MAX_W(MAX_W), .MIN_W(MIN_W), .WREQ_W(WREQ_W)) u_width (
        .clk        (clk),
        .rst        (rst),
        .load_i     (pos.frame_end),
        .req_i      (width_i),
        .width_o    (width_q),
        .cap_en_o   (cap_en),
        .stage_en_o (stage_en_o)
    );

    assign seed = (pos.kind == SLOT_HOLD)   && pos.last;
    assign step = (pos.kind == SLOT_DECIDE) && pos.last;

    sar_bit_reg #(.MAX_W(MAX_W)) u_bits (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (pos.frame_end),
        .seed_i      (seed),
        .step_i      (step),
        .comp_i      (comp_i),
        .cap_en_i    (cap_en),
        .bits_o      (bits),
        .bits_next_o (bits_next),
        .finish_o    (finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish)
                result_q <= bits_next;
        end
    end

    always_comb begin
        unique case (pos.kind)
            SLOT_SAMPLE: cap_drv_o = cap_en;
            SLOT_HOLD:   cap_drv_o = pos.first ? cap_en : '0;
            SLOT_DECIDE: cap_drv_o = bits;
            default:     cap_drv_o = '0;
        endcase
    end

    assign ref_sw_o   = (pos.kind == SLOT_SAMPLE);
    assign comp_rst_o = !((pos.kind == SLOT_DECIDE) && !pos.first);
    assign cap_en_o   = cap_en;
    assign result_o   = result_q;
    assign done_o     = done_q;

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
    parameter int unsigned MAX_W = 8,
    parameter int unsigned MIN_W = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   ref_sw_o,
    input logic [MAX_W-1:0]       cap_en_o,
    input logic [MAX_W-MIN_W-1:0] stage_en_o,
    input logic [MAX_W-1:0]       cap_drv_o,
    input logic                   comp_rst_o,
    input logic [MAX_W-1:0]       result_o,
    input logic                   done_o
);
    // R6
    a_r6_off_caps_grounded: assert property (@(posedge clk) disable iff (rst)
        (cap_drv_o & ~cap_en_o) == '0);

    // R7
    a_r7_thermometer: assert property (@(posedge clk) disable iff (rst)
        (stage_en_o & (stage_en_o + 1'b1)) == '0);

    // R5
    a_r5_plates_at_ref_on_open: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_sw_o) |-> (cap_drv_o == cap_en_o));

    // R5
    a_r5_plates_ground_after: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_sw_o) |=> (cap_drv_o == '0));

    // R4
    a_r4_sample_two_cycles: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_sw_o) |=> ref_sw_o);

    // R8
    a_r8_reset_while_sampling: assert property (@(posedge clk) disable iff (rst)
        ref_sw_o |-> comp_rst_o);

    // R10
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10
    a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    // R2
    a_r2_width_at_frame: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_en_o) |-> $rose(ref_sw_o));

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_sw_o   (ref_sw_o),
    .cap_en_o   (cap_en_o),
    .stage_en_o (stage_en_o),
    .cap_drv_o  (cap_drv_o),
    .comp_rst_o (comp_rst_o),
    .result_o   (result_o),
    .done_o     (done_o)
);

// File: tb/sar_seq_ctrl_test.sv
module sar_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] width_i = 4'd8;
    logic       comp_i;
    logic       ref_sw_o;
    logic [7:0] cap_en_o;
    logic [4:0] stage_en_o;
    logic [7:0] cap_drv_o;
    logic       comp_rst_o;
    logic [7:0] result_o;
    logic       done_o;

    int    vin = 0;
    string drv_tag = "R11";
    int    checks = 0;
    int    errors = 0;

    // model state
    int    mc = 0, mw = 8, msar = 0, mres = 0, mdone = 0;
    int    cur_vin = 0, cur_n = 8;
    string cur_tag = "R11";
    int    slot, ph, dec, en, st, exp_drv, b, nd;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_seq_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .width_i    (width_i),
        .comp_i     (comp_i),
        .ref_sw_o   (ref_sw_o),
        .cap_en_o   (cap_en_o),
        .stage_en_o (stage_en_o),
        .cap_drv_o  (cap_drv_o),
        .comp_rst_o (comp_rst_o),
        .result_o   (result_o),
        .done_o     (done_o)
    );

    // behavioural comparator: DAC level scaled to 8 bits by the enabled count
    assign comp_i = (vin >= (int'(cap_drv_o) << (8 - $countones(cap_en_o))));

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int clampw(input int w);
        if (w < 3) return 3;
        if (w > 8) return 8;
        return w;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            mc = 0; mw = 8; msar = 0; mres = 0; mdone = 0;
        end else begin
            slot = mc / 2;
            ph   = mc % 2;
            dec  = (slot >= 2 && slot < 2 + mw) ? 1 : 0;
            en   = (1 << mw) - 1;
            st   = 0;
            for (int k = 0; k < 5; k++) if (mw > 3 + k) st |= (1 << k);
            if (slot == 0 || (slot == 1 && ph == 0)) exp_drv = en;
            else if (dec != 0) exp_drv = msar;
            else exp_drv = 0;

            chk("R4", int'(ref_sw_o), (slot == 0) ? 1 : 0, "ref_sw");
            chk("R6", int'(cap_en_o), en, "cap_en");
            chk("R7", int'(stage_en_o), st, "stage_en");
            chk((dec != 0) ? "R9" : "R5", int'(cap_drv_o), exp_drv, "cap_drv");
            chk("R8", int'(comp_rst_o), (dec != 0 && ph == 1) ? 0 : 1, "comp_rst");
            chk("R3", int'(done_o), mdone, "done");
            chk("R10", int'(result_o), mres, "result");
            if (mdone != 0)
                chk(cur_tag, int'(result_o), cur_vin >> (8 - cur_n), "converted value");
            if (mc == 0) begin
                cur_vin = vin; cur_n = mw; cur_tag = drv_tag;
            end

            nd = 0;
            if (mc == 3) begin
                msar = 1 << (mw - 1);
            end else if (dec != 0 && ph == 1) begin
                b = mw - 1 - (slot - 2);
                if (!comp_i) msar &= ~(1 << b);
                if (b == 0) begin
                    mres = msar; nd = 1;
                end else begin
                    msar |= (1 << (b - 1));
                end
            end
            if (mc == 19) begin
                msar = 0;
                mw = clampw(int'(width_i));
            end
            mdone = nd;
            mc = (mc + 1) % 20;
        end
    end

    task automatic conv(input int w, input int v, input string tag);
        do @(posedge clk); while (mc != 19);
        #1 width_i = 4'(w);
        @(posedge clk);
        #1 vin = v; drv_tag = tag;
    endtask

    task automatic conv_glitch(input int w, input int v, input int bad);
        conv(w, v, "R2");
        do @(posedge clk); while (mc != 6);
        #1 width_i = 4'(bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #1;
        // R11: reset state, cycle 0 at full width
        chk("R11", int'(result_o), 0, "result after reset");
        chk("R11", int'(done_o), 0, "done after reset");
        chk("R11", int'(ref_sw_o), 1, "sampling after reset");
        chk("R11", int'(cap_en_o), 255, "full width after reset");

        // R9: full width, rails, mid-scale and alternating bits
        conv(8, 0, "R9");
        conv(8, 255, "R9");
        conv(8, 128, "R9");
        conv(8, 127, "R9");
        conv(8, 165, "R9");
        conv(8, 90, "R9");
        // R6 R7 R9: each reduced width
        conv(7, 200, "R9");
        conv(6, 77, "R9");
        conv(5, 255, "R9");
        conv(4, 129, "R9");
        conv(3, 224, "R9");
        conv(3, 31, "R9");
        // R1: out-of-range requests clamp
        conv(0, 170, "R1");
        conv(2, 100, "R1");
        conv(9, 85, "R1");
        conv(15, 254, "R1");
        // R2: mid-frame width changes ignored
        conv_glitch(8, 201, 3);
        conv_glitch(3, 201, 8);
        conv_glitch(5, 66, 0);
        conv(8, 3, "R2");
        conv(3, 250, "R2");
        conv(8, 250, "R2");
        conv(8, 0, "R9");
        repeat (45) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule